// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block keeps the byte count that a host programs for a DMA transfer and turns it into the length the data mover must actually move. The host loads the count one byte at a time into two write-only holding bytes, a low byte and a middle byte. The count moves into the host-visible counter only when a command arrives with its DMA flag set. A command without the flag switches DMA mode off and leaves the visible counter as it is.

When a transfer starts, the block forms the effective length and loads it into a remaining-length register. A stored count of zero stands for 65536. In data mode the effective length is the smaller of the count and the pending data size. In command mode it is the smaller of the count and 32. The data mover acknowledges each chunk it moves, and the remaining length drops by the chunk size. Completion comes either from the remaining length reaching zero or from an external done strobe. On completion the block raises terminal count and an interrupt request, and it clears the visible counter.

A two-state machine controls the work. In `S_IDLE` the block accepts register writes, commands and starts. The transition START_MOVE goes to `S_MOVE` when a start arrives with a non-zero effective length. The transition START_EMPTY stays in `S_IDLE` and completes at once when the effective length is zero. In `S_MOVE` the transition FINISH returns to `S_IDLE` when the remaining length hits zero or done_in is seen. The transition HOLD stays in `S_MOVE` otherwise.

Top module: `dma_len_counter`

## Requirements
- R1: A wr_lo or wr_mid strobe stores wr_data in the low or middle holding byte. The visible counter cnt_rd (middle byte in bits 15:8, low byte in bits 7:0) does not change until a DMA-flagged command is issued.
- R2: cmd_valid with cmd_dma=1 copies both holding bytes into cnt_rd and turns DMA mode on. cmd_valid with cmd_dma=0 turns DMA mode off and leaves cnt_rd unchanged.
- R3: A write strobe to either count byte clears tc on the next edge, unless a completion happens on that same edge.
- R4: A cnt_rd value of zero is taken as a count of 65536 (0x10000) when the effective length is formed.
- R5: On an accepted xfer_start, eff_len is latched and tc is cleared. eff_len is min(count, pend_size) when cmd_mode=0 and min(count, 32) when cmd_mode=1. A start is accepted only in DMA mode and in S_IDLE; any other start is ignored.
- R6: In S_MOVE, each mv_ack reduces remain by mv_amt. The value saturates at zero and never wraps.
- R7: Completion happens on the same edge where an acknowledge brings remain to zero, or on the edge where done_in is high in S_MOVE. busy then falls.
- R8: On completion, tc and irq go to 1 and cnt_rd goes to 0. The holding bytes are kept, so a later DMA command reloads the earlier count.
- R9: An accepted start whose effective length is zero completes on that same edge and never enters S_MOVE.
- R10: irq stays high until irq_ack. If completion and irq_ack fall on the same edge, completion wins.
- R11: After reset, tc, irq, busy, cnt_rd, eff_len and remain are all 0 and DMA mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_lo | input | 1 | Write strobe for the low count byte |
| wr_mid | input | 1 | Write strobe for the middle count byte |
| wr_data | input | BYTE_W | Byte written by either strobe |
| cmd_valid | input | 1 | Command issue strobe |
| cmd_dma | input | 1 | DMA flag of the issued command |
| xfer_start | input | 1 | Start a transfer |
| cmd_mode | input | 1 | 1 = command-phase transfer, capped at 32 |
| pend_size | input | LEN_W | Pending data size for data mode |
| mv_ack | input | 1 | Data mover moved a chunk |
| mv_amt | input | AMT_W | Size of the moved chunk |
| done_in | input | 1 | External end of transfer |
| irq_ack | input | 1 | Host clears the interrupt |
| eff_len | output | LEN_W | Effective length latched at start |
| remain | output | LEN_W | Remaining length |
| cnt_rd | output | 2*BYTE_W | Host-visible counter |
| busy | output | 1 | High in S_MOVE |
| tc | output | 1 | Terminal-count status |
| irq | output | 1 | Interrupt request |

## Verification
The table-driven pass covers several cases. A count below the pending size and a pending size below the count show that the minimum is taken. A zero count shows that it widens to 65536. The two command-mode rows show the cap of 32 against counts above and below it. Each row is drained with 200-byte chunks, and the acknowledge count confirms that the final chunk saturates rather than wraps. Directed cases cover the rest. A non-DMA command with a start shows both are ignored. A zero pending size shows the immediate completion. done_in in mid-transfer shows the external finish. Reloading after completion shows that the holding bytes are kept. Write-after-completion and irq_ack show that tc and irq clear independently.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_MOVE = 1'b1
    } dlc_state_e;
endpackage

// File: rtl/dlc_shadow.sv
module dlc_shadow #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_mid,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                reload,
    input  logic                clear,
    output logic [2*BYTE_W-1:0] cnt_o
);
    logic [BYTE_W-1:0] hold_lo, hold_mid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_lo  <= '0;
            hold_mid <= '0;
        end else begin
            if (wr_lo)  hold_lo  <= wr_data;
            if (wr_mid) hold_mid <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_o <= '0;
        else if (clear)  cnt_o <= '0;
        else if (reload) cnt_o <= {hold_mid, hold_lo};
    end
endmodule

// File: rtl/dlc_len_calc.sv
module dlc_len_calc #(
    parameter int CNT_W   = 16,
    parameter int LEN_W   = CNT_W + 1,
    parameter int CMD_CAP = 32
) (
    input  logic [CNT_W-1:0] count,
    input  logic             cmd_mode,
    input  logic [LEN_W-1:0] pend,
    output logic [LEN_W-1:0] len_o
);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(1) << CNT_W;
    localparam logic [LEN_W-1:0] CAP  = LEN_W'(CMD_CAP);

    logic [LEN_W-1:0] count_ext, limit;

    always_comb begin
        count_ext = (count == '0) ? FULL : LEN_W'(count);
        limit     = cmd_mode ? CAP : pend;
        len_o     = (count_ext < limit) ? count_ext : limit;
    end
endmodule

// File: rtl/dlc_remain.sv
module dlc_remain #(
    parameter int LEN_W = 17,
    parameter int AMT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    input  logic [AMT_W-1:0] amt,
    output logic [LEN_W-1:0] remain_o,
    output logic             zero_hit
);
    logic [LEN_W-1:0] amt_ext, next_val;

    always_comb begin
        amt_ext  = LEN_W'(amt);
        next_val = (amt_ext >= remain_o) ? '0 : remain_o - amt_ext;
        zero_hit = dec && (next_val == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    remain_o <= '0;
        else if (load) remain_o <= load_val;
        else if (dec)  remain_o <= next_val;
    end
endmodule

// File: rtl/dma_len_counter.sv
module dma_len_counter #(
    parameter int BYTE_W  = 8,
    parameter int LEN_W   = 2 * BYTE_W + 1,
    parameter int AMT_W   = 8,
    parameter int CMD_CAP = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_mid,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                cmd_valid,
    input  logic                cmd_dma,
    input  logic                xfer_start,
    input  logic                cmd_mode,
    input  logic [LEN_W-1:0]    pend_size,
    input  logic                mv_ack,
    input  logic [AMT_W-1:0]    mv_amt,
    input  logic                done_in,
    input  logic                irq_ack,
    output logic [LEN_W-1:0]    eff_len,
    output logic [LEN_W-1:0]    remain,
    output logic [2*BYTE_W-1:0] cnt_rd,
    output logic                busy,
    output logic                tc,
    output logic                irq
);
    import dlc_pkg::*;
    localparam int CNT_W = 2 * BYTE_W;

    dlc_state_e       state, state_nx;
    logic             dma_mode;
    logic [LEN_W-1:0] calc_len;
    logic             start_ok, zero_len, dec_zero, move_done, complete;

    dlc_shadow #(.BYTE_W(BYTE_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_mid(wr_mid),
        .wr_data(wr_data), .reload(cmd_valid && cmd_dma),
        .clear(complete), .cnt_o(cnt_rd)
    );

    dlc_len_calc #(.CNT_W(CNT_W), .LEN_W(LEN_W), .CMD_CAP(CMD_CAP)) u_calc (
        .count(cnt_rd), .cmd_mode(cmd_mode), .pend(pend_size), .len_o(calc_len)
    );

    dlc_remain #(.LEN_W(LEN_W), .AMT_W(AMT_W)) u_remain (
        .clk(clk), .rst_n(rst_n), .load(start_ok), .load_val(calc_len),
        .dec((state == S_MOVE) && mv_ack), .amt(mv_amt),
        .remain_o(remain), .zero_hit(dec_zero)
    );

    always_comb begin
        start_ok  = xfer_start && dma_mode && (state == S_IDLE);
        zero_len  = start_ok && (calc_len == '0);
        move_done = (state == S_MOVE) && (dec_zero || done_in);
        complete  = zero_len || move_done;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start_ok && !zero_len) state_nx = S_MOVE;  // START_MOVE
            S_MOVE: if (move_done)             state_nx = S_IDLE;  // FINISH
            default:                           state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_mode <= 1'b0;
            eff_len  <= '0;
            tc       <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (cmd_valid) dma_mode <= cmd_dma;
            if (start_ok)  eff_len  <= calc_len;
            if (complete)                          tc <= 1'b1;
            else if (wr_lo || wr_mid || start_ok)  tc <= 1'b0;
            if (complete)     irq <= 1'b1;
            else if (irq_ack) irq <= 1'b0;
        end
    end

    assign busy = (state == S_MOVE);
endmodule

// File: rtl/dma_len_counter_chk.sv
module dma_len_counter_chk #(
    parameter int BYTE_W = 8,
    parameter int LEN_W  = 2 * BYTE_W + 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_lo,
    input logic                wr_mid,
    input logic                cmd_valid,
    input logic                cmd_dma,
    input logic                xfer_start,
    input logic                irq_ack,
    input logic [LEN_W-1:0]    eff_len,
    input logic [LEN_W-1:0]    remain,
    input logic [2*BYTE_W-1:0] cnt_rd,
    input logic                busy,
    input logic                tc,
    input logic                irq
);
    assert_wr_clears_tc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo || wr_mid) && !busy && !xfer_start |=> !tc);

    assert_nodma_keeps_cnt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_dma && !busy && !xfer_start |=> $stable(cnt_rd));

    assert_remain_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain <= eff_len) && (remain != '0));

    assert_finish_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> tc && irq);

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> tc && (cnt_rd == '0));

    assert_irq_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_ack |=> irq);
endmodule

bind dma_len_counter dma_len_counter_chk #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_mid(wr_mid),
    .cmd_valid(cmd_valid), .cmd_dma(cmd_dma), .xfer_start(xfer_start),
    .irq_ack(irq_ack), .eff_len(eff_len), .remain(remain), .cnt_rd(cnt_rd),
    .busy(busy), .tc(tc), .irq(irq)
);

// File: tb/dma_len_counter_test.sv
module dma_len_counter_test;
    localparam int NV = 6;
    localparam int CHUNK = 200;

    localparam logic [7:0]  V_LO  [NV] = '{8'h20, 8'h00, 8'h00, 8'h00, 8'h10, 8'h34};
    localparam logic [7:0]  V_MID [NV] = '{8'h00, 8'h01, 8'h00, 8'h00, 8'h00, 8'h12};
    localparam logic        V_CMD [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [16:0] V_PEND[NV] = '{17'h100, 17'h80, 17'h1FFFF, 17'h0, 17'h0, 17'h1234};
    localparam logic [16:0] V_EXP [NV] = '{17'h20, 17'h80, 17'h10000, 17'h20, 17'h10, 17'h1234};

    logic        clk = 0, rst_n = 0;
    logic        wr_lo = 0, wr_mid = 0, cmd_valid = 0, cmd_dma = 0;
    logic        xfer_start = 0, cmd_mode = 0, mv_ack = 0, done_in = 0, irq_ack = 0;
    logic [7:0]  wr_data = 0, mv_amt = 0;
    logic [16:0] pend_size = 0;
    logic [16:0] eff_len, remain;
    logic [15:0] cnt_rd;
    logic        busy, tc, irq;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    dma_len_counter uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_byte(input bit mid, input logic [7:0] d);
        @(negedge clk); wr_data = d; wr_lo = !mid; wr_mid = mid;
        @(negedge clk); wr_lo = 0; wr_mid = 0;
    endtask

    task automatic issue(input bit dma);
        @(negedge clk); cmd_valid = 1; cmd_dma = dma;
        @(negedge clk); cmd_valid = 0; cmd_dma = 0;
    endtask

    task automatic start(input bit mode, input logic [16:0] pend);
        @(negedge clk); xfer_start = 1; cmd_mode = mode; pend_size = pend;
        @(negedge clk); xfer_start = 0;
    endtask

    task automatic drain(output int n);
        n = 0;
        @(negedge clk); mv_ack = 1; mv_amt = 8'(CHUNK);
        do begin
            @(negedge clk); n++;
        end while (busy && n < 2000);
        mv_ack = 0;
    endtask

    task automatic clr_irq();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 tc", tc, 0); check("R11 irq", irq, 0); check("R11 busy", busy, 0);
        check("R11 cnt_rd", cnt_rd, 0); check("R11 eff_len", eff_len, 0);
        rst_n = 1;
        // R2 start ignored while DMA mode is off
        start(0, 17'h40);
        check("R2 start ignored busy", busy, 0);
        check("R2 start ignored eff_len", eff_len, 0);

        for (int i = 0; i < NV; i++) begin
            wr_byte(0, V_LO[i]);
            wr_byte(1, V_MID[i]);
            check("R1 cnt_rd before reload", cnt_rd, 0);
            issue(1);
            check("R2 reload", cnt_rd, {V_MID[i], V_LO[i]});
            start(V_CMD[i], V_PEND[i]);
            check("R4 R5 eff_len", eff_len, V_EXP[i]);
            check("R5 tc cleared at start", tc, 0);
            check("R5 busy", busy, 1);
            drain(n);
            check("R6 R7 ack count", n, (int'(V_EXP[i]) + CHUNK - 1) / CHUNK);
            check("R8 tc", tc, 1); check("R8 irq", irq, 1);
            check("R8 cnt_rd cleared", cnt_rd, 0);
            check("R6 remain saturated", remain, 0);
            clr_irq();
            check("R10 irq cleared", irq, 0);
            check("R10 tc kept", tc, 1);
        end

        // R3 write clears tc, irq unaffected; R1 no reload
        wr_byte(0, 8'h05);
        check("R3 tc cleared", tc, 0);
        check("R1 cnt_rd unchanged", cnt_rd, 0);
        // R2 non-DMA command does not reload
        issue(0);
        check("R2 no reload", cnt_rd, 0);
        start(0, 17'h10);
        check("R2 start ignored", busy, 0);
        // R8 holding bytes kept: reload gives 0x1205
        issue(1);
        check("R8 holding kept", cnt_rd, 16'h1205);
        // R9 zero pending completes at once
        start(0, 17'h0);
        check("R9 busy", busy, 0); check("R9 tc", tc, 1); check("R9 irq", irq, 1);
        clr_irq();
        // R7 external done + R6 single decrement + R5 busy start ignored
        wr_byte(0, 8'h20); wr_byte(1, 8'h00); issue(1);
        start(0, 17'h100);
        @(negedge clk); mv_ack = 1; mv_amt = 8'd5;
        @(negedge clk); mv_ack = 0;
        check("R6 remain", remain, 17'h1B);
        start(0, 17'h3);
        check("R5 busy start ignored", eff_len, 17'h20);
        @(negedge clk); done_in = 1; irq_ack = 1;
        @(negedge clk); done_in = 0; irq_ack = 0;
        check("R7 done busy", busy, 0); check("R7 done tc", tc, 1);
        check("R10 completion beats ack", irq, 1);
        // R11 reset again
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        check("R11 reset irq", irq, 0); check("R11 reset tc", tc, 0);
        check("R11 reset remain", remain, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule